// File: doc/BRIEF.md
# Supply Supervisor with Watchdog Reset

This block owns a system reset and drives it as a pair of complementary outputs, one active-high and one active-low. It combines two kinds of supervision. The first is a supply check: an undervoltage flag arrives already synchronized and already carrying hysteresis. The second is a watchdog that needs regular falling edges on a heartbeat input. All intervals are counted in ticks of a timebase strobe. Analog sensing and capacitor timing are handled outside the block.

Reset is held during power-up and for as long as the supply is low. Once the supply is good, reset stays on for a fixed hold interval and is then released. After release the watchdog watch window opens. Each heartbeat falling edge restarts the window. If a window expires without an edge, the block issues a reset pulse of fixed length and then opens a fresh window. An inhibit input parks the watchdog, for example while the processor is in standby, while supply monitoring carries on. The defaults for hold, window and pulse lengths are 100, 10 and 2 ticks.

All pins are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `supply_supervisor`

## Requirements
- R1: While `sup_low_i` is 1 at a rising clock edge, the block is in the hold phase after that edge, with reset asserted, whatever phase it was in before.
- R2: In the hold phase, reset is released on the clock edge that accepts the HOLD_TICKS-th tick counted while the supply is good. The tick count starts at zero on entry to the hold phase.
- R3: The heartbeat passes through a two-flop synchronizer. A 1-to-0 change of `hb_i` present before rising edge k restarts the watch window at edge k+2. A 0-to-1 change has no effect on the window.
- R4: If the watch window accepts WATCH_TICKS ticks with no recognised falling edge and inhibit low, reset is asserted for PULSE_TICKS ticks.
- R5: On the edge that accepts the last tick of the watchdog pulse, reset is released and a fresh watch window starts counting from zero.
- R6: While `wd_inhibit_i` is 1, the watch count is held at zero and no watchdog pulse starts. `sup_low_i` still forces the hold phase.
- R7: `rst_lo_o` is the exact complement of `rst_hi_o` in every cycle.
- R8: A synchronous block reset `rst` puts the block into the hold phase with reset asserted and clears the heartbeat synchronizer to 0.
- R9: If the supply drops during a watchdog pulse, the pulse is abandoned and the full hold sequence restarts from zero.
- R10: When a recognised falling edge and a tick reach the watch window in the same cycle, the edge wins and the count restarts at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous block reset, active high |
| tick_i | input | 1 | Timebase strobe, one clock wide per tick |
| sup_low_i | input | 1 | Synchronized undervoltage flag with hysteresis |
| hb_i | input | 1 | Asynchronous heartbeat from the supervised processor |
| wd_inhibit_i | input | 1 | Parks the watchdog while high |
| rst_hi_o | output | 1 | System reset, active high |
| rst_lo_o | output | 1 | System reset, active low |

## Verification
The hardest case to reach is a supply dip that falls inside the short watchdog pulse. The pulse exists only after a full hold interval and a full empty watch window, and it lasts just a few ticks. The stimulus withholds heartbeat edges and follows the bench model's phase cycle by cycle. It raises the undervoltage flag in the first cycle the model reports a pulse in progress, then checks that the whole hold interval starts again. The same phase-following approach places a heartbeat edge exactly on a tick cycle, which exercises the edge-over-tick priority.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_WATCH = 2'd1,
    PH_PULSE = 2'd2
  } phase_t;
endpackage

// File: rtl/hb_falldet.sv
module hb_falldet #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hb_i,
  output logic fall_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], hb_i};
      last_q <= sync_q[MSB];
    end
  end

  assign fall_o = last_q & ~sync_q[MSB];

  // R3: a detected edge never persists two cycles in a row
  p_fall_single_r3: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import sup_pkg::*;
#(
  parameter int HOLD_TICKS  = 100,
  parameter int WATCH_TICKS = 10,
  parameter int PULSE_TICKS = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick_i,
  input  logic   sup_low_i,
  input  logic   fall_i,
  input  logic   inhibit_i,
  output phase_t phase_o
);
  localparam int MAX_A = (HOLD_TICKS > WATCH_TICKS) ? HOLD_TICKS : WATCH_TICKS;
  localparam int MAX_T = (MAX_A > PULSE_TICKS) ? MAX_A : PULSE_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] WATCH_LAST = CW'(WATCH_TICKS - 1);
  localparam logic [CW-1:0] PULSE_LAST = CW'(PULSE_TICKS - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || sup_low_i) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_HOLD: if (tick_i) begin
          if (cnt_q == HOLD_LAST) begin
            phase_q <= PH_WATCH;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_WATCH: begin
          if (fall_i || inhibit_i) cnt_q <= '0;
          else if (tick_i) begin
            if (cnt_q == WATCH_LAST) begin
              phase_q <= PH_PULSE;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_PULSE: if (tick_i) begin
          if (cnt_q == PULSE_LAST) begin
            phase_q <= PH_WATCH;
            cnt_q   <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          phase_q <= PH_HOLD;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;

  p_low_forces_hold_r1: assert property (@(posedge clk) disable iff (rst)
    sup_low_i |=> phase_q == PH_HOLD);
  p_block_reset_hold_r8: assert property (@(posedge clk)
    rst |=> phase_q == PH_HOLD && cnt_q == '0);
  p_no_timeout_inhibit_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WATCH && inhibit_i && !sup_low_i) |=> phase_q == PH_WATCH && cnt_q == '0);
  p_edge_restart_r10: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WATCH && fall_i && !sup_low_i) |=> phase_q == PH_WATCH && cnt_q == '0);
  p_pulse_from_watch_r4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PULSE && $past(phase_q) != PH_PULSE) |-> $past(phase_q) == PH_WATCH);
  p_pulse_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_PULSE && !sup_low_i && tick_i && cnt_q == PULSE_LAST) |=>
      phase_q == PH_WATCH && cnt_q == '0);
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import sup_pkg::*;
#(
  parameter int HOLD_TICKS  = 100,
  parameter int WATCH_TICKS = 10,
  parameter int PULSE_TICKS = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic sup_low_i,
  input  logic hb_i,
  input  logic wd_inhibit_i,
  output logic rst_hi_o,
  output logic rst_lo_o
);
  logic   hb_fall;
  phase_t phase;

  hb_falldet #(.SYNC_STAGES(SYNC_STAGES)) u_hb (
    .clk    (clk),
    .rst    (rst),
    .hb_i   (hb_i),
    .fall_o (hb_fall)
  );

  phase_ctrl #(
    .HOLD_TICKS  (HOLD_TICKS),
    .WATCH_TICKS (WATCH_TICKS),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .sup_low_i (sup_low_i),
    .fall_i    (hb_fall),
    .inhibit_i (wd_inhibit_i),
    .phase_o   (phase)
  );

  assign rst_hi_o = (phase != PH_WATCH);
  assign rst_lo_o = ~rst_hi_o;

  p_low_holds_reset_r1: assert property (@(posedge clk) disable iff (rst)
    sup_low_i |=> rst_hi_o && !rst_lo_o);
endmodule

// File: tb/supply_supervisor_bench.sv
`timescale 1ns/1ps
module supply_supervisor_bench;
  localparam int HOLD  = 12;
  localparam int WATCH = 6;
  localparam int PULSE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic sup_low = 1'b1;
  logic hb = 1'b0;
  logic inh = 1'b0;
  logic rst_hi, rst_lo;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int ph = 0;   // 0 hold, 1 watch, 2 pulse
  int cnt = 0;
  bit h1 = 0, h2 = 0, hl = 0;
  bit done = 0;
  bit fall_now = 0;

  always #2.5 clk = ~clk;

  supply_supervisor #(.HOLD_TICKS(HOLD), .WATCH_TICKS(WATCH), .PULSE_TICKS(PULSE))
  u_supply_supervisor (
    .clk(clk), .rst(rst), .tick_i(tick), .sup_low_i(sup_low), .hb_i(hb),
    .wd_inhibit_i(inh), .rst_hi_o(rst_hi), .rst_lo_o(rst_lo)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    fall_now = hl & ~h2;
    if (rst || sup_low) begin
      ph = 0; cnt = 0;
    end else begin
      case (ph)
        0: if (tick) begin
             if (cnt == HOLD - 1) begin ph = 1; cnt = 0; end else cnt++;
           end
        1: if (fall_now || inh) cnt = 0;
           else if (tick) begin
             if (cnt == WATCH - 1) begin ph = 2; cnt = 0; end else cnt++;
           end
        default: if (tick) begin
             if (cnt == PULSE - 1) begin ph = 1; cnt = 0; end else cnt++;
           end
      endcase
    end
    if (rst) begin h1 = 0; h2 = 0; hl = 0; end
    else begin hl = h2; h2 = h1; h1 = hb; end
    @(negedge clk);
    check(tag, rst_hi, (ph != 1));
    check("R7", rst_lo, ~rst_hi);
    cyc++;
    tick = (cyc % 2 == 0);
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    steps(4, "R8");
    rst = 1'b0;
    steps(6, "R1");
    sup_low = 1'b0;
    steps(2 * HOLD + 4, "R2");
    check("R2", ph == 1, 1'b1);

    // Heartbeat falling every 4 ticks keeps the reset released
    for (int k = 0; k < 6; k++) begin
      hb = 1'b1; steps(4, "R3");
      hb = 1'b0; steps(4, "R3");
    end
    check("R3", ph == 1, 1'b1);

    // Only rising edges: the window must time out
    hb = 1'b1;
    steps(2 * WATCH + 2, "R3");
    check("R4", ph == 2, 1'b1);
    steps(2 * PULSE + 2, "R5");
    check("R5", ph == 1, 1'b1);

    // Inhibit: no timeout over a long silent stretch
    inh = 1'b1;
    steps(8 * WATCH, "R6");
    check("R6", ph == 1, 1'b1);
    sup_low = 1'b1; steps(2, "R6");
    sup_low = 1'b0; steps(2 * HOLD + 4, "R6");
    inh = 1'b0;

    // Edge on a tick cycle: wait for a tick two cycles ahead
    while (!(ph == 1 && cyc % 2 == 0)) step("R10");
    hb = 1'b0;
    steps(3, "R10");
    steps(2 * WATCH - 2, "R10");
    check("R10", ph == 1, 1'b1);

    // Supply dip during the watchdog pulse
    for (int g = 0; g < 4 * WATCH + 8 && ph != 2; g++) step("R4");
    check("R9", ph == 2, 1'b1);
    sup_low = 1'b1; step("R9");
    sup_low = 1'b0;
    steps(2 * HOLD - 2, "R9");
    check("R9", ph == 0, 1'b1);
    steps(6, "R9");
    check("R9", ph == 1, 1'b1);

    // Block reset from the running phase
    rst = 1'b1; steps(2, "R8");
    rst = 1'b0; steps(4, "R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule